// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Controller

This block is the command and status front end of a network controller. The host writes 16-bit command words to one port. Each word holds a 5-bit opcode and an 11-bit argument. Commands select the active register window, acknowledge latched events, load the interrupt mask, raise a software interrupt, switch the receiver and transmitter on and off, and start a global reset. Any argument bits a command does not use are ignored.

The transmit and receive datapaths report events as single-cycle pulses. Each event is held in a 16-bit status word until the host acknowledges it. The status word also reports the selected window and a command-busy flag. A single interrupt output is raised whenever an unmasked event is pending. A neighbouring register decoder reads the current window from a dedicated output.

Top module: `cmd_status_ctrl`

## Requirements
- R1: After reset, status_o is 0x0000, window_o is 0, and irq_o, rx_en_o and tx_en_o are low.
- R2: A command with opcode 1 (word bits 15..11) sets the window to argument bits 2..0 on the next cycle. Status bits 15..13 and window_o report that window.
- R3: A pulse on evt_i[k], for k in {1,2,3,4,5,7}, sets status bit k on the next cycle. The bit stays set until it is acknowledged. Pulses on evt_i[0] and evt_i[6] have no effect. Status bits 11..8 always read 0.
- R4: Opcode 13 clears every latched status bit whose matching bit in argument bits 7..0 is set, and leaves the other bits alone. If an event arrives in the same cycle as the acknowledge that clears its bit, the event wins.
- R5: Opcode 12 sets status bit 6 (interrupt requested).
- R6: Opcode 14 loads the interrupt mask from argument bits 7..0. irq_o is high exactly when some k in 1..7 has both status bit k and mask bit k set. Mask bit 0 has no effect.
- R7: Status bit 0 is set in the cycle after irq_o rises. Only an acknowledge or a global reset clears it.
- R8: Opcode 4 raises rx_en_o and opcode 3 lowers it. Opcode 9 raises tx_en_o and opcode 10 lowers it. Both outputs are low after reset.
- R9: Opcode 0 (global reset) clears the latched bits, the mask, the window and both enables. It then holds status bit 12 high for BUSY_CYCLES cycles. While that bit is high, commands and event pulses are ignored.
- R10: Commands with any other opcode (2, 5 to 8, 11, 15 to 31) change no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe, one cycle per word |
| cmd_wdata_i | input | 16 | Command word: opcode in bits 15..11, argument in bits 10..0 |
| evt_i | input | 8 | Event pulses, one per status bit position |
| status_o | output | 16 | Status word: window, busy flag, latched events |
| window_o | output | 3 | Selected register window |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receiver enabled |
| tx_en_o | output | 1 | Transmitter enabled |

## Verification
Every window number is written with noisy upper argument bits, which tells a field-width or field-offset slip apart from correct decoding. The mask sweep covers all 256 mask values against each event source, so a wrong mask bit, a mask applied to bit 0, or a missing OR term shows up as a wrong irq_o. Single-bit acknowledges on a full status word, and an acknowledge arriving in the same cycle as an event, separate a clear-all from a per-bit clear and show which of the two wins. A sweep of every unused opcode, plus commands and events issued during the busy window, shows whether anything leaks through the gating.

// File: rtl/cmd_status_pkg.sv
package cmd_status_pkg;
  localparam int CMD_W = 16;
  localparam int OP_W  = 5;
  localparam int ARG_W = CMD_W - OP_W;
  localparam int EVT_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_GRESET   = 5'd0,
    OP_WINDOW   = 5'd1,
    OP_RX_DIS   = 5'd3,
    OP_RX_EN    = 5'd4,
    OP_TX_EN    = 5'd9,
    OP_TX_DIS   = 5'd10,
    OP_REQ_INT  = 5'd12,
    OP_ACK      = 5'd13,
    OP_SET_MASK = 5'd14
  } opcode_e;

  typedef struct packed {
    logic greset;
    logic win_sel;
    logic rx_dis;
    logic rx_en;
    logic tx_en;
    logic tx_dis;
    logic req_int;
    logic ack;
    logic set_mask;
  } cmd_strobe_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_status_pkg::*;
(
  input  logic             valid_i,
  input  logic [CMD_W-1:0] word_i,
  output cmd_strobe_t      strb_o,
  output logic [EVT_W-1:0] arg_o
);
  logic [OP_W-1:0] op;
  logic            unused_arg;

  assign op         = word_i[CMD_W-1:ARG_W];
  assign arg_o      = word_i[EVT_W-1:0];
  assign unused_arg = ^word_i[ARG_W-1:EVT_W];

  always_comb begin
    strb_o = '0;
    if (valid_i) begin
      case (op)
        OP_GRESET:   strb_o.greset   = 1'b1;
        OP_WINDOW:   strb_o.win_sel  = 1'b1;
        OP_RX_DIS:   strb_o.rx_dis   = 1'b1;
        OP_RX_EN:    strb_o.rx_en    = 1'b1;
        OP_TX_EN:    strb_o.tx_en    = 1'b1;
        OP_TX_DIS:   strb_o.tx_dis   = 1'b1;
        OP_REQ_INT:  strb_o.req_int  = 1'b1;
        OP_ACK:      strb_o.ack      = 1'b1;
        OP_SET_MASK: strb_o.set_mask = 1'b1;
        default:     strb_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o) else $error("busy not raised"); // R9
  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CYCLES)) else $error("busy count out of range"); // R9
endmodule

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int EVT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic [EVT_W-1:0] set_i,
  input  logic [EVT_W-1:0] ack_i,
  input  logic             mask_we_i,
  input  logic [EVT_W-1:0] mask_i,
  output logic [EVT_W-1:0] lat_o,
  output logic             irq_o
);
  localparam logic [EVT_W-1:0] NO_LSB = {{(EVT_W-1){1'b1}}, 1'b0};

  logic [EVT_W-1:0] lat_q, mask_q, set_eff;
  logic             irq_prev_q, rise;

  assign irq_o   = |(lat_q[EVT_W-1:1] & mask_q[EVT_W-1:1]);
  assign rise    = irq_o & ~irq_prev_q;
  assign set_eff = (set_i & NO_LSB) | {{(EVT_W-1){1'b0}}, rise};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q      <= '0;
      mask_q     <= '0;
      irq_prev_q <= 1'b0;
    end else begin
      irq_prev_q <= irq_o;
      if (clr_all_i) begin
        lat_q  <= '0;
        mask_q <= '0;
      end else begin
        lat_q <= (lat_q & ~ack_i) | set_eff;  // set wins over ack
        if (mask_we_i) mask_q <= mask_i;
      end
    end
  end

  assign lat_o = lat_q;

  AST_EVT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(set_i & NO_LSB)) && !clr_all_i) |=> ((lat_q & $past(set_i & NO_LSB)) == $past(set_i & NO_LSB)))
    else $error("event not latched"); // R3
  AST_ACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|ack_i) && !(|set_i)) |=> ((lat_q & $past(ack_i) & NO_LSB) == '0))
    else $error("ack did not clear"); // R4
  AST_RISE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && !clr_all_i) |=> lat_q[0])
    else $error("latch bit missed irq rise"); // R7
endmodule

// File: rtl/cmd_status_ctrl.sv
module cmd_status_ctrl
  import cmd_status_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [CMD_W-1:0] status_o,
  output logic [2:0]       window_o,
  output logic             irq_o,
  output logic             rx_en_o,
  output logic             tx_en_o
);
  localparam int WIN_W   = 3;
  localparam int REQ_BIT = 6;
  localparam int RSV_W   = CMD_W - WIN_W - 1 - EVT_W;
  localparam logic [EVT_W-1:0] HW_EVT = 8'b1011_1110;

  cmd_strobe_t      strb;
  logic [EVT_W-1:0] arg, lat, set_vec, ack_vec;
  logic             busy, cmd_valid;
  logic [WIN_W-1:0] win_q;
  logic             rx_q, tx_q;

  assign cmd_valid = cmd_we_i & ~busy;

  cmd_decode i_dec (
    .valid_i (cmd_valid),
    .word_i  (cmd_wdata_i),
    .strb_o  (strb),
    .arg_o   (arg)
  );

  busy_timer #(.CYCLES(BUSY_CYCLES)) i_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (strb.greset),
    .busy_o  (busy)
  );

  assign set_vec = (busy ? '0 : (evt_i & HW_EVT))
                 | (EVT_W'(strb.req_int) << REQ_BIT);
  assign ack_vec = strb.ack ? arg : '0;

  evt_latch #(.EVT_W(EVT_W)) i_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (strb.greset),
    .set_i     (set_vec),
    .ack_i     (ack_vec),
    .mask_we_i (strb.set_mask),
    .mask_i    (arg),
    .lat_o     (lat),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else if (strb.greset) begin
      win_q <= '0;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      if (strb.win_sel) win_q <= arg[WIN_W-1:0];
      if (strb.rx_en)   rx_q  <= 1'b1;
      if (strb.rx_dis)  rx_q  <= 1'b0;
      if (strb.tx_en)   tx_q  <= 1'b1;
      if (strb.tx_dis)  tx_q  <= 1'b0;
    end
  end

  assign window_o = win_q;
  assign rx_en_o  = rx_q;
  assign tx_en_o  = tx_q;
  assign status_o = {win_q, busy, {RSV_W{1'b0}}, lat};

  AST_WIN_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && strb.win_sel) |=> (status_o[CMD_W-1 -: WIN_W] == $past(arg[WIN_W-1:0])))
    else $error("window not selected"); // R2
  AST_REQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && strb.req_int) |=> status_o[REQ_BIT])
    else $error("requested interrupt not set"); // R5
  AST_RX_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && strb.rx_en) |=> rx_en_o) else $error("rx not enabled"); // R8
  AST_TX_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && strb.tx_dis) |=> !tx_en_o) else $error("tx not disabled"); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_we_i) |=> ($stable(window_o) && $stable(rx_en_o) && $stable(tx_en_o)))
    else $error("command taken while busy"); // R9
  AST_UNKNOWN_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid && (strb == '0)) |=> ($stable(window_o) && $stable(rx_en_o) && $stable(tx_en_o)))
    else $error("unknown opcode had effect"); // R10
endmodule

// File: tb/test_cmd_status_ctrl.sv
module test_cmd_status_ctrl;
  localparam int N_BUSY = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_wd = '0;
  logic [7:0]  evt = '0;
  logic [15:0] status;
  logic [2:0]  window;
  logic        irq, rx_en, tx_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [7:0] m_lat = '0, m_mask = '0;
  logic [2:0] m_win = '0;
  logic       m_rx = 1'b0, m_tx = 1'b0, m_prev = 1'b0;
  int         m_cnt = 0;

  always #5 clk = ~clk;

  cmd_status_ctrl #(.BUSY_CYCLES(N_BUSY)) i_cmd_status_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
    .evt_i(evt), .status_o(status), .window_o(window), .irq_o(irq),
    .rx_en_o(rx_en), .tx_en_o(tx_en)
  );

  function automatic logic [15:0] cw(input int op, input int arg);
    return {op[4:0], arg[10:0]};
  endfunction

  task automatic model_edge(input logic we, input logic [15:0] w, input logic [7:0] ev);
    logic       irq_cur, rise, gr;
    logic [7:0] set, ack;
    irq_cur = |(m_lat[7:1] & m_mask[7:1]);
    rise = irq_cur & ~m_prev;
    m_prev = irq_cur;
    set = '0; ack = '0; gr = 1'b0;
    if (m_cnt != 0) begin
      m_cnt--;
    end else begin
      set = ev & 8'hBE;
      if (we) begin
        case (int'(w[15:11]))
          0:  gr = 1'b1;
          1:  m_win = w[2:0];
          3:  m_rx = 1'b0;
          4:  m_rx = 1'b1;
          9:  m_tx = 1'b1;
          10: m_tx = 1'b0;
          12: set[6] = 1'b1;
          13: ack = w[7:0];
          14: m_mask = w[7:0];
          default: ;
        endcase
      end
      if (gr) begin
        m_cnt = N_BUSY; m_lat = '0; m_mask = '0; m_win = '0; m_rx = 1'b0; m_tx = 1'b0;
      end
    end
    if (!gr) m_lat = (m_lat & ~ack) | set | {7'd0, rise};
  endtask

  task automatic check(input string tag);
    logic [15:0] es;
    logic        ei;
    es = {m_win, (m_cnt != 0), 4'b0, m_lat};
    ei = |(m_lat[7:1] & m_mask[7:1]);
    checks++;
    if (status !== es || irq !== ei || window !== m_win || rx_en !== m_rx || tx_en !== m_tx) begin
      fails++;
      $display("FAIL %s: status=%h irq=%b win=%0d rx=%b tx=%b expected status=%h irq=%b win=%0d rx=%b tx=%b",
               tag, status, irq, window, rx_en, tx_en, es, ei, m_win, m_rx, m_tx);
    end
  endtask

  task automatic step(input logic we, input logic [15:0] w, input logic [7:0] ev, input string tag);
    @(negedge clk);
    cmd_we = we; cmd_wd = w; evt = ev;
    @(posedge clk);
    model_edge(we, w, ev);
    #1;
    cmd_we = 1'b0; evt = '0;
    check(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1 check("R1");

    // R2: every window, noisy high argument bits
    for (int w = 0; w < 8; w++) step(1'b1, cw(1, 11'h7F8 | w), '0, "R2");
    step(1'b1, cw(1, 3), '0, "R2");

    // R3: each event line alone, then clear
    for (int k = 0; k < 8; k++) begin
      step(1'b0, '0, 8'(1 << k), "R3");
      step(1'b0, '0, '0, "R3");
      step(1'b1, cw(13, 8'hFF), '0, "R3");
    end

    // R4: full word, single-bit acks; event vs ack collision
    step(1'b0, '0, 8'hBE, "R4");
    for (int k = 0; k < 8; k++) step(1'b1, cw(13, 1 << k), '0, "R4");
    step(1'b0, '0, 8'h14, "R4");
    step(1'b1, cw(13, 8'h14), 8'h04, "R4");
    step(1'b1, cw(13, 8'hFF), '0, "R4");

    // R5
    step(1'b1, cw(12, 11'h7FF), '0, "R5");
    step(1'b1, cw(13, 8'h40), '0, "R5");

    // R6/R7: every mask against every source
    for (int m = 0; m < 256; m++) begin
      step(1'b1, cw(14, m), '0, "R6");
      for (int k = 1; k < 8; k++) begin
        if (k == 6) step(1'b1, cw(12, 0), '0, "R6");
        else        step(1'b0, '0, 8'(1 << k), "R6");
        step(1'b0, '0, '0, "R7");
        step(1'b1, cw(13, 8'hFF), '0, "R7");
        step(1'b0, '0, '0, "R7");
      end
    end
    // R7: bit 0 held until acknowledged
    step(1'b1, cw(14, 8'h10), '0, "R7");
    step(1'b0, '0, 8'h10, "R7");
    step(1'b1, cw(13, 8'h10), '0, "R7");
    step(1'b0, '0, '0, "R7");
    step(1'b1, cw(13, 8'h01), '0, "R7");

    // R8
    step(1'b1, cw(4, 0), '0, "R8");
    step(1'b1, cw(9, 0), '0, "R8");
    step(1'b1, cw(3, 11'h7FF), '0, "R8");
    step(1'b1, cw(4, 0), '0, "R8");
    step(1'b1, cw(10, 0), '0, "R8");
    step(1'b1, cw(9, 0), '0, "R8");

    // R10: every unused opcode with a full argument
    step(1'b1, cw(1, 5), '0, "R10");
    step(1'b1, cw(14, 8'hFE), '0, "R10");
    step(1'b0, '0, 8'h08, "R10");
    for (int op = 2; op < 32; op++) begin
      if (!(op inside {3, 4, 9, 10, 12, 13, 14})) step(1'b1, cw(op, 11'h7FF), '0, "R10");
    end

    // R9: global reset, busy window, ignored traffic
    step(1'b1, cw(0, 11'h7FF), '0, "R9");
    for (int i = 0; i < N_BUSY + 2; i++) begin
      if (i % 3 == 0)      step(1'b1, cw(1, 6), '0, "R9");
      else if (i % 3 == 1) step(1'b1, cw(4, 0), 8'hFF, "R9");
      else                 step(1'b1, cw(0, 0), '0, "R9");
    end
    step(1'b1, cw(1, 6), 8'h02, "R9");
    step(1'b1, cw(0, 0), '0, "R9");
    repeat (N_BUSY + 1) step(1'b0, '0, '0, "R9");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule